// File: doc/BRIEF.md
# IN Endpoint Transmit Controller

This block holds the transmit-side decisions for a single device-mode IN endpoint that can run as bulk, interrupt or isochronous. It keeps a count of the packets that are waiting in the endpoint FIFO. The count can reach one slot, or two slots when double buffering is on. When the host's IN token arrives, the block chooses the reply: a data packet, a NAK, or a zero-length packet. It also owns the data toggle and releases slots once delivery is settled.

A FIFO loader pulses `pkt_loaded` once it has finished writing each packet. The serializer reports each `in_token` and, for handshaked modes, the handshake result. The block answers with a one-cycle response on `rsp_valid`, `rsp_kind` and `rsp_toggle`. A DMA engine can watch `dma_req`. Software sees `ep_irq` and two sticky error flags, and clears each of them by pulsing its clear input. FIFO storage, bit serialization and the DMA engine are outside the block.

Top module: `usb_in_ep_tx`

## Requirements
- R1: After reset the packet count is 0, the toggle is DATA0, no response is valid, and `ep_irq`, `underrun_sts` and `overflow_sts` are all 0.
- R2: The slot capacity is 1 when `cfg_dbl_buf`=0 and 2 when it is 1. A `pkt_loaded` pulse raises `pkt_count` by one at the next edge. A pulse that arrives while the count equals the capacity leaves the count unchanged and sets the sticky `overflow_sts`, which `clr_overflow` clears.
- R3: In bulk (`cfg_xfer_type`=0) or interrupt (=1) mode with forced toggle off, a token with a packet ready returns DATA (`rsp_kind`=1) carrying the current toggle. The slot and the toggle stay put until `hs_ack`, which frees the slot and flips the toggle. On `hs_timeout` the packet stays queued and the toggle does not change, so the next token resends it with the same toggle.
- R4: In bulk or interrupt mode, a token with no packet ready returns NAK (`rsp_kind`=2). It raises no interrupt and sets no error flag.
- R5: In bulk or interrupt mode with `cfg_force_tog`=1, a token with a packet ready returns DATA. At that same edge the slot is freed and the toggle flips, with no handshake needed.
- R6: In isochronous mode (`cfg_xfer_type`=2), a token with a packet ready returns DATA with `rsp_toggle`=0 (DATA0). The slot is freed at that edge and the stored toggle does not change.
- R7: In isochronous mode, a token with no packet ready returns a zero-length packet (`rsp_kind`=3), sets the sticky `underrun_sts` and sets `ep_irq`. This happens in DMA mode too. `clr_underrun` clears the flag.
- R8: `dma_req` is 1 exactly when `cfg_dma_en`=1 and `pkt_count` is below the capacity.
- R9: Each freed slot sets `ep_irq` unless both `cfg_dma_en` and `cfg_dma_mode` are 1. A `clr_irq` pulse clears `ep_irq`, and a set in the same cycle wins over the clear.
- R10: The response is valid for exactly the one cycle after the token's edge. A token that arrives while a handshake is still awaited gets no response and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_xfer_type | input | 2 | 0 bulk, 1 interrupt, 2 isochronous |
| cfg_dbl_buf | input | 1 | Allow two queued packets |
| cfg_force_tog | input | 1 | Treat every sent packet as delivered |
| cfg_dma_en | input | 1 | Enable DMA request |
| cfg_dma_mode | input | 1 | With DMA on, suppress completion interrupts |
| pkt_loaded | input | 1 | Pulse: one packet written into the FIFO |
| in_token | input | 1 | Pulse: IN token for this endpoint |
| hs_ack | input | 1 | Pulse: host acknowledged the last data |
| hs_timeout | input | 1 | Pulse: no handshake arrived |
| clr_irq | input | 1 | Write-1 clear of the interrupt |
| clr_underrun | input | 1 | Write-1 clear of the underrun flag |
| clr_overflow | input | 1 | Write-1 clear of the overflow flag |
| rsp_valid | output | 1 | Response valid |
| rsp_kind | output | 2 | 1 DATA, 2 NAK, 3 zero-length |
| rsp_toggle | output | 1 | Data PID toggle of the response |
| pkt_count | output | 2 | Packets waiting |
| dma_req | output | 1 | FIFO can take another packet |
| ep_irq | output | 1 | Endpoint interrupt |
| underrun_sts | output | 1 | Sticky isochronous underrun |
| overflow_sts | output | 1 | Sticky load-when-full |

## Verification
Every input is sampled at one rising edge, and its result appears at the outputs just after that edge. The response to a token, the new count after a load, ACK or release, the toggle flip, the sticky flags and the interrupt are therefore all due one cycle after the stimulus. `dma_req` follows the count with no extra register. The bench drives inputs on the falling edge. After the rising edge it advances a behavioural model and compares every output against it on the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/usb_in_ep_pkg.sv
// Shared types for the IN endpoint transmit controller.
// Assumes: transfer type and response codes are fixed two-bit encodings.
package usb_in_ep_pkg;
    typedef enum logic [1:0] {
        XF_BULK = 2'd0,
        XF_INTR = 2'd1,
        XF_ISO  = 2'd2,
        XF_RSVD = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_DATA = 2'd1,
        RSP_NAK  = 2'd2,
        RSP_ZLP  = 2'd3
    } rsp_e;
endpackage

// File: rtl/usb_in_ep_slots.sv
// Counts the packets that are ready in the endpoint FIFO and flags loads that arrive when full.
// Assumes: release is only raised while the count is non-zero.
module usb_in_ep_slots #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cap,
    input  logic             load,
    input  logic             release_slot,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] count,
    output logic             ovf_sts
);
    logic             load_ok;
    logic [CNT_W-1:0] count_nxt;

    // Work out the next count: an accepted load adds one, a release takes one away.
    always_comb begin
        load_ok   = load && (count < cap);
        count_nxt = count;
        if (load_ok)      count_nxt = count_nxt + CNT_W'(1);
        if (release_slot) count_nxt = count_nxt - CNT_W'(1);
    end

    // Register the count and the sticky overflow flag; a new overflow wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            ovf_sts <= 1'b0;
        end else begin
            count <= count_nxt;
            if (load && !load_ok) ovf_sts <= 1'b1;
            else if (clr_ovf)     ovf_sts <= 1'b0;
        end
    end
endmodule

// File: rtl/usb_in_ep_seq.sv
// Chooses the reply to each IN token, keeps the data toggle and tracks the awaited handshake.
// Assumes: tokens, acks and timeouts are one-cycle pulses from the serializer.
module usb_in_ep_seq
    import usb_in_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  xfer_e      xfer,
    input  logic       force_tog,
    input  logic       have_pkt,
    input  logic       in_token,
    input  logic       hs_ack,
    input  logic       hs_timeout,
    output logic       rsp_valid,
    output rsp_e       rsp_kind,
    output logic       rsp_toggle,
    output logic       release_slot,
    output logic       underrun
);
    logic is_iso, take, send, acked, timed_out, start_wait, tog_flip;
    logic toggle, await_hs;

    // Decode this cycle's events from the token, handshake and mode.
    always_comb begin
        is_iso       = (xfer == XF_ISO);
        take         = in_token && !await_hs;
        send         = take && have_pkt;
        acked        = await_hs && hs_ack;
        timed_out    = await_hs && hs_timeout && !hs_ack;
        start_wait   = send && !is_iso && !force_tog;
        release_slot = (send && (is_iso || force_tog)) || acked;
        underrun     = take && !have_pkt && is_iso;
        tog_flip     = (send && force_tog && !is_iso) || acked;
    end

    // Hold the toggle and the awaiting-handshake state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toggle   <= 1'b0;
            await_hs <= 1'b0;
        end else begin
            if (tog_flip) toggle <= ~toggle;
            if (start_wait)              await_hs <= 1'b1;
            else if (acked || timed_out) await_hs <= 1'b0;
        end
    end

    // Register the one-cycle response to an accepted token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_kind   <= RSP_NONE;
            rsp_toggle <= 1'b0;
        end else begin
            rsp_valid  <= take;
            rsp_toggle <= send && !is_iso && toggle;
            if (send)      rsp_kind <= RSP_DATA;
            else if (take) rsp_kind <= is_iso ? RSP_ZLP : RSP_NAK;
            else           rsp_kind <= RSP_NONE;
        end
    end
endmodule

// File: rtl/usb_in_ep_irq.sv
// Raises the endpoint interrupt on completions and errors and keeps the underrun flag.
// Assumes: clears are write-1 pulses; a set in the same cycle wins.
module usb_in_ep_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_freed,
    input  logic underrun,
    input  logic dma_en,
    input  logic dma_mode,
    input  logic clr_irq,
    input  logic clr_underrun,
    output logic ep_irq,
    output logic underrun_sts
);
    logic irq_set;

    // A completion counts unless DMA mode hides it; an underrun always counts.
    always_comb irq_set = (slot_freed && !(dma_en && dma_mode)) || underrun;

    // Keep the interrupt and the sticky underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep_irq       <= 1'b0;
            underrun_sts <= 1'b0;
        end else begin
            if (irq_set)      ep_irq <= 1'b1;
            else if (clr_irq) ep_irq <= 1'b0;
            if (underrun)          underrun_sts <= 1'b1;
            else if (clr_underrun) underrun_sts <= 1'b0;
        end
    end
endmodule

// File: rtl/usb_in_ep_tx.sv
// Top of the IN endpoint transmit controller: slot count, reply choice, toggle, DMA request, interrupt.
// Assumes: all strobes are synchronous one-cycle pulses; configuration is stable while traffic runs.
module usb_in_ep_tx
    import usb_in_ep_pkg::*;
#(
    parameter int SLOT_MAX = 2,
    localparam int CNT_W = $clog2(SLOT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_xfer_type,
    input  logic             cfg_dbl_buf,
    input  logic             cfg_force_tog,
    input  logic             cfg_dma_en,
    input  logic             cfg_dma_mode,
    input  logic             pkt_loaded,
    input  logic             in_token,
    input  logic             hs_ack,
    input  logic             hs_timeout,
    input  logic             clr_irq,
    input  logic             clr_underrun,
    input  logic             clr_overflow,
    output logic             rsp_valid,
    output logic [1:0]       rsp_kind,
    output logic             rsp_toggle,
    output logic [CNT_W-1:0] pkt_count,
    output logic             dma_req,
    output logic             ep_irq,
    output logic             underrun_sts,
    output logic             overflow_sts
);
    logic [CNT_W-1:0] cap;
    logic             freed, underrun;
    rsp_e             kind;

    // Capacity follows the double-buffer setting; the DMA request follows free space.
    always_comb begin
        cap      = cfg_dbl_buf ? CNT_W'(SLOT_MAX) : CNT_W'(1);
        dma_req  = cfg_dma_en && (pkt_count < cap);
        rsp_kind = kind;
    end

    usb_in_ep_slots #(.CNT_W(CNT_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .cap(cap), .load(pkt_loaded),
        .release_slot(freed), .clr_ovf(clr_overflow),
        .count(pkt_count), .ovf_sts(overflow_sts)
    );

    usb_in_ep_seq u_seq (
        .clk(clk), .rst_n(rst_n), .xfer(xfer_e'(cfg_xfer_type)),
        .force_tog(cfg_force_tog), .have_pkt(pkt_count != '0),
        .in_token(in_token), .hs_ack(hs_ack), .hs_timeout(hs_timeout),
        .rsp_valid(rsp_valid), .rsp_kind(kind), .rsp_toggle(rsp_toggle),
        .release_slot(freed), .underrun(underrun)
    );

    usb_in_ep_irq u_irq (
        .clk(clk), .rst_n(rst_n), .slot_freed(freed), .underrun(underrun),
        .dma_en(cfg_dma_en), .dma_mode(cfg_dma_mode), .clr_irq(clr_irq),
        .clr_underrun(clr_underrun), .ep_irq(ep_irq), .underrun_sts(underrun_sts)
    );
endmodule

// File: rtl/usb_in_ep_tx_chk.sv
// Checker for the IN endpoint transmit controller, bound to the top module.
// Assumes: reset is held for at least one edge before traffic.
module usb_in_ep_tx_chk #(
    parameter int SLOT_MAX = 2,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg_xfer_type,
    input logic             cfg_dbl_buf,
    input logic             pkt_loaded,
    input logic             in_token,
    input logic             rsp_valid,
    input logic [1:0]       rsp_kind,
    input logic             rsp_toggle,
    input logic [CNT_W-1:0] pkt_count,
    input logic             ep_irq,
    input logic             underrun_sts,
    input logic             overflow_sts
);
    logic [CNT_W-1:0] cap_c;
    always_comb cap_c = cfg_dbl_buf ? CNT_W'(SLOT_MAX) : CNT_W'(1);

    // R2: the count never exceeds the capacity
    a_r2_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_count <= cap_c);

    // R2: a load while full sets the overflow flag
    a_r2_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_loaded && pkt_count == cap_c) |=> overflow_sts);

    // R10: a response follows a token by one cycle
    a_r10_rsp_after_token: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(in_token));

    // R4: a NAK only comes from an empty endpoint
    a_r4_nak_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd2) |-> $past(pkt_count) == '0);

    // R6: isochronous data is always DATA0
    a_r6_iso_data0: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd1 && $past(cfg_xfer_type) == 2'd2) |-> !rsp_toggle);

    // R7: a new underrun comes with the interrupt
    a_r7_underrun_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_sts) |-> ep_irq);
endmodule

bind usb_in_ep_tx usb_in_ep_tx_chk #(.SLOT_MAX(SLOT_MAX), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_xfer_type(cfg_xfer_type), .cfg_dbl_buf(cfg_dbl_buf),
    .pkt_loaded(pkt_loaded), .in_token(in_token), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .rsp_toggle(rsp_toggle), .pkt_count(pkt_count),
    .ep_irq(ep_irq), .underrun_sts(underrun_sts), .overflow_sts(overflow_sts)
);

// File: tb/usb_in_ep_tx_bench.sv
module usb_in_ep_tx_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_xfer_type = 2'd0;
    logic cfg_dbl_buf = 1'b0, cfg_force_tog = 1'b0, cfg_dma_en = 1'b1, cfg_dma_mode = 1'b0;
    logic pkt_loaded = 1'b0, in_token = 1'b0, hs_ack = 1'b0, hs_timeout = 1'b0;
    logic clr_irq = 1'b0, clr_underrun = 1'b0, clr_overflow = 1'b0;
    logic rsp_valid, rsp_toggle, dma_req, ep_irq, underrun_sts, overflow_sts;
    logic [1:0] rsp_kind, pkt_count;

    int n_checks = 0, n_fail = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0, m_tog = 0, m_await = 0, m_irq = 0, m_und = 0, m_ovf = 0;
    int m_rv = 0, m_rk = 0, m_rt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_in_ep_tx u_usb_in_ep_tx (.*);

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic model_step();
        int cap, take, send, freed, set_irq;
        cap = cfg_dbl_buf ? 2 : 1;
        take = in_token && !m_await;
        send = take && (m_cnt > 0);
        freed = 0; set_irq = 0;
        m_rv = take; m_rk = 0; m_rt = 0;
        if (take) begin
            if (cfg_xfer_type == 2) begin
                if (send) begin m_rk = 1; freed = 1; end
                else begin m_rk = 3; m_und = 1; set_irq = 1; end
            end else if (send) begin
                m_rk = 1; m_rt = m_tog;
                if (cfg_force_tog) begin freed = 1; m_tog ^= 1; end
                else m_await = 1;
            end else m_rk = 2;
        end else if (m_await && hs_ack) begin
            freed = 1; m_tog ^= 1; m_await = 0;
        end else if (m_await && hs_timeout) m_await = 0;
        if (!set_irq && clr_underrun) m_und = 0;
        if (pkt_loaded && m_cnt == cap) m_ovf = 1;
        else if (clr_overflow) m_ovf = 0;
        if (pkt_loaded && m_cnt < cap) m_cnt++;
        if (freed) begin
            m_cnt--;
            if (!(cfg_dma_en && cfg_dma_mode)) set_irq = 1;
        end
        if (set_irq) m_irq = 1;
        else if (clr_irq) m_irq = 0;
    endtask

    task automatic compare_all();
        int cap;
        cap = cfg_dbl_buf ? 2 : 1;
        chk("rsp_valid", rsp_valid, m_rv);
        chk("rsp_kind", m_rv ? int'(rsp_kind) : m_rk, m_rk);
        chk("rsp_toggle", m_rk == 1 ? int'(rsp_toggle) : m_rt, m_rt);
        chk("pkt_count", pkt_count, m_cnt);
        chk("dma_req R8", dma_req, (cfg_dma_en && m_cnt < cap) ? 1 : 0);
        chk("ep_irq", ep_irq, m_irq);
        chk("underrun_sts", underrun_sts, m_und);
        chk("overflow_sts", overflow_sts, m_ovf);
    endtask

    // one cycle: strobes applied before the edge, model advanced at it, outputs compared after
    task automatic tick(bit ld, bit tk, bit ak, bit to, bit ci = 0, bit cu = 0, bit co = 0);
        pkt_loaded = ld; in_token = tk; hs_ack = ak; hs_timeout = to;
        clr_irq = ci; clr_underrun = cu; clr_overflow = co;
        @(posedge clk);
        model_step();
        @(negedge clk);
        pkt_loaded = 0; in_token = 0; hs_ack = 0; hs_timeout = 0;
        clr_irq = 0; clr_underrun = 0; clr_overflow = 0;
        compare_all();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";  compare_all(); tick(0,0,0,0);

        cur_req = "R2";  tick(1,0,0,0); tick(1,0,0,0); tick(0,0,0,0,0,0,1);
        cfg_dbl_buf = 1; tick(1,0,0,0); tick(1,0,0,0);
        tick(0,0,0,0,0,0,1);

        cur_req = "R3";  tick(0,1,0,0);
        cur_req = "R10"; tick(0,1,0,0); tick(0,0,0,0);
        cur_req = "R3";  tick(0,0,0,1); tick(0,1,0,0); tick(0,0,1,0);
        tick(0,1,0,0); tick(0,0,0,1); tick(0,1,0,0); tick(0,0,1,0);
        cur_req = "R9";  tick(0,0,0,0,1);
        cur_req = "R4";  tick(0,1,0,0); tick(0,0,0,0);
        cfg_xfer_type = 2'd1; tick(0,1,0,0);

        cur_req = "R5";  cfg_force_tog = 1; tick(1,0,0,0); tick(1,1,0,0);
        tick(0,1,0,0); tick(0,0,0,0,1); tick(0,1,0,0);
        cfg_force_tog = 0;

        cur_req = "R6";  cfg_xfer_type = 2'd2; tick(1,0,0,0); tick(0,1,0,0);
        cfg_xfer_type = 2'd0; tick(1,1,0,0); tick(0,0,1,0);
        cfg_xfer_type = 2'd2; tick(0,1,0,0,1);

        cur_req = "R7";  cfg_dma_mode = 1; tick(0,0,0,0,1); tick(0,1,0,0);
        tick(0,0,0,0,1,1); tick(0,1,0,0,1,1);
        cur_req = "R9";  tick(0,0,0,0,1,1); tick(1,0,0,0); tick(0,1,0,0);
        cfg_dma_mode = 0; tick(1,0,0,0); tick(0,1,0,0,1);
        cur_req = "R8";  cfg_dma_en = 0; tick(0,0,0,0,1); tick(1,0,0,0);
        cfg_dma_en = 1; tick(1,0,0,0); tick(1,1,0,0);
        cur_req = "R10"; cfg_xfer_type = 2'd1; tick(0,1,0,0); tick(0,1,1,0); tick(0,0,0,0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule